// File: doc/BRIEF.md
# Ethernet Destination Address Filter

The filter decides, one frame at a time, whether a received frame should be kept, based only on its 48-bit destination MAC address. A lookup request carries the address; one clock later the block answers with an accept flag, a code saying which rule accepted the frame, and, for an exact hit, the index of the matching table entry.

Three rules are tried in a fixed order. First, per-class accept bits: broadcast, multicast and unicast addresses each have their own bit. Second, a table of 16 exact-match entries, compared against the address in parallel. Third, an inexact lookup in a 4096-bit multicast hash table, indexed by a 12-bit slice of the last two address bytes. A 2-bit offset picks where that slice is taken from. Both tables are loaded through simple write ports. After reset, entry 0 holds the station address and is marked valid.

Top module: `mac_dest_filter`

## Requirements
- R1: An all-ones destination is broadcast; with `bcast_accept` set it is accepted with source code 1.
- R2: A non-broadcast destination whose bit 0 of byte 0 (`req_dest[0]`, byte 0 being `req_dest[7:0]` and byte 5 `req_dest[47:40]`) is set is multicast and is accepted with code 1 when `mcast_promisc` is set. Any other non-broadcast address is unicast and is accepted with code 1 when `ucast_promisc` is set.
- R3: Exact entry i holds a low word (bytes 0..3, byte 0 in bits 7:0) and a high word (bytes 4..5 in bits 15:0, valid flag in bit 31). A valid entry equal to the destination accepts it with code 2 and reports i on `rsp_index`.
- R4: Entries whose valid flag is clear never produce a match.
- R5: When several valid entries match, the lowest index is reported.
- R6: The hash slot is the 16-bit value {byte5, byte4} shifted right by 4, 3, 2 or 0 for `hash_offset` 0, 1, 2 or 3 and masked to 12 bits. Slot bits [11:5] select table word `hash_wr_idx`, and bits [4:0] select a bit in it. A set bit accepts with code 3.
- R7: A frame accepted by no rule gives `rsp_accept`=0 and code 0. `rsp_index` is 0 whenever the code is not 2, and `rsp_accept` is 1 exactly when the code is non-zero.
- R8: The rules are tried in priority order class (1), then exact (2), then hash (3).
- R9: After reset, entry 0 holds `station_addr` and is valid, every other entry is invalid, and every hash bit is clear.
- R10: A response appears one cycle after its request (`rsp_valid` follows `req_valid` by one cycle). A table write in the same cycle as a lookup is not seen by that lookup.
- R11: A broadcast destination with `bcast_accept` clear is not accepted by `mcast_promisc` or `ucast_promisc`; it goes on to the table lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| station_addr | input | 48 | Address loaded into entry 0 while in reset |
| bcast_accept | input | 1 | Accept broadcast frames |
| mcast_promisc | input | 1 | Accept every multicast frame |
| ucast_promisc | input | 1 | Accept every unicast frame |
| hash_offset | input | 2 | Selects the hash slice shift |
| ent_wr_en | input | 1 | Exact-table write strobe |
| ent_wr_idx | input | 4 | Exact-table entry to write |
| ent_wr_hi | input | 1 | 1 writes the high word, 0 the low word |
| ent_wr_data | input | 32 | Exact-table write data |
| hash_wr_en | input | 1 | Hash-table write strobe |
| hash_wr_idx | input | 7 | Hash-table word to write |
| hash_wr_data | input | 32 | Hash-table word data |
| req_valid | input | 1 | Lookup request |
| req_dest | input | 48 | Destination address to classify |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_accept | output | 1 | Frame accepted |
| rsp_src | output | 2 | 0 reject, 1 class, 2 exact, 3 hash |
| rsp_index | output | 4 | Matching exact entry, else 0 |

## Verification
The assertions assume that `req_dest` and the control bits are stable in the cycle a request is sampled. They also assume that `rst_n` is held low for at least one clock edge, so that entry 0 picks up `station_addr`. The bench changes every input only on the falling edge and keeps reset low for several cycles. Its random addresses are drawn so that class, exact and hash outcomes all occur: some are copies of live entries, some are broadcast, and the accept bits are set only rarely.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  typedef enum logic [1:0] {
    SRC_REJECT = 2'd0,
    SRC_CLASS  = 2'd1,
    SRC_EXACT  = 2'd2,
    SRC_HASH   = 2'd3
  } match_src_e;

  // Shift applied to {byte5, byte4} for each offset code.
  function automatic logic [3:0] slice_shift(input logic [1:0] off);
    case (off)
      2'd0:    slice_shift = 4'd4;
      2'd1:    slice_shift = 4'd3;
      2'd2:    slice_shift = 4'd2;
      default: slice_shift = 4'd0;
    endcase
  endfunction

  // 12-bit hash slot taken from the last two address bytes.
  function automatic logic [11:0] hash_slot(input logic [47:0] dest,
                                            input logic [1:0]  off);
    logic [15:0] tail;
    logic [15:0] moved;
    tail  = {dest[47:40], dest[39:32]};
    moved = tail >> slice_shift(off);
    hash_slot = moved[11:0];
  endfunction

endpackage

// File: rtl/mdf_class_check.sv
module mdf_class_check (
  input  logic [47:0] dest,
  input  logic        bcast_accept,
  input  logic        mcast_promisc,
  input  logic        ucast_promisc,
  output logic        is_bcast,
  output logic        is_mcast,
  output logic        class_hit
);
  always_comb begin
    is_bcast = &dest;
    is_mcast = !is_bcast && dest[0];
    if (is_bcast)      class_hit = bcast_accept;
    else if (is_mcast) class_hit = mcast_promisc;
    else               class_hit = ucast_promisc;
  end
endmodule

// File: rtl/mdf_exact_table.sv
module mdf_exact_table #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      station_addr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic [47:0]      dest,
  output logic             found,
  output logic [IDX_W-1:0] found_idx
);
  localparam int VALID_BIT = 31;

  logic [31:0]          lo_word [N_ENTRIES];
  logic [15:0]          hi_addr [N_ENTRIES];
  logic [N_ENTRIES-1:0] valid_vec;
  logic [N_ENTRIES-1:0] hit_vec;

  genvar gi;
  generate
    for (gi = 0; gi < N_ENTRIES; gi++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          if (gi == 0) begin
            lo_word[gi]   <= station_addr[31:0];
            hi_addr[gi]   <= station_addr[47:32];
            valid_vec[gi] <= 1'b1;
          end else begin
            lo_word[gi]   <= '0;
            hi_addr[gi]   <= '0;
            valid_vec[gi] <= 1'b0;
          end
        end else if (wr_en && wr_idx == IDX_W'(gi)) begin
          if (wr_hi) begin
            hi_addr[gi]   <= wr_data[15:0];
            valid_vec[gi] <= wr_data[VALID_BIT];
          end else begin
            lo_word[gi]   <= wr_data;
          end
        end
      end
      assign hit_vec[gi] = valid_vec[gi] && ({hi_addr[gi], lo_word[gi]} == dest);
    end
  endgenerate

  // Lowest index wins.
  always_comb begin
    found     = 1'b0;
    found_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found     = 1'b1;
        found_idx = IDX_W'(i);
      end
    end
  end

  // R3: a reported index is one whose comparison really hit.
  assert_found_is_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> hit_vec[found_idx]);
  // R4: an invalid entry never raises its hit line.
  assert_invalid_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~valid_vec) == '0);
  // R5: no hit below the reported index.
  assert_lowest_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((hit_vec & ((N_ENTRIES'(1) << found_idx) - N_ENTRIES'(1))) == '0));
endmodule

// File: rtl/mdf_hash_table.sv
module mdf_hash_table #(
  parameter int SLOT_W = 12,
  localparam int WORD_W = 32,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WSEL_W = SLOT_W - BIT_W,
  localparam int N_WORDS = 1 << WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] slot,
  output logic              hit
);
  logic [WORD_W-1:0] words [N_WORDS];
  logic [WORD_W-1:0] sel_word;

  genvar gw;
  generate
    for (gw = 0; gw < N_WORDS; gw++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[gw] <= '0;
        else if (wr_en && wr_idx == WSEL_W'(gw))
          words[gw] <= wr_data;
      end
    end
  endgenerate

  assign sel_word = words[slot[SLOT_W-1:BIT_W]];
  assign hit      = sel_word[slot[BIT_W-1:0]];

  // R6: a hit requires a non-empty selected word.
  assert_hash_word_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (sel_word != '0));
endmodule

// File: rtl/mac_dest_filter.sv
module mac_dest_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] station_addr,
  input  logic        bcast_accept,
  input  logic        mcast_promisc,
  input  logic        ucast_promisc,
  input  logic [1:0]  hash_offset,
  input  logic        ent_wr_en,
  input  logic [3:0]  ent_wr_idx,
  input  logic        ent_wr_hi,
  input  logic [31:0] ent_wr_data,
  input  logic        hash_wr_en,
  input  logic [6:0]  hash_wr_idx,
  input  logic [31:0] hash_wr_data,
  input  logic        req_valid,
  input  logic [47:0] req_dest,
  output logic        rsp_valid,
  output logic        rsp_accept,
  output logic [1:0]  rsp_src,
  output logic [3:0]  rsp_index
);
  import mdf_pkg::*;

  localparam int N_ENTRIES = 16;
  localparam int SLOT_W    = 12;
  localparam int IDX_W     = $clog2(N_ENTRIES);

  logic              is_bcast, is_mcast, class_hit;
  logic              exact_hit;
  logic [IDX_W-1:0]  exact_idx;
  logic              hash_hit;
  logic [SLOT_W-1:0] slot;
  match_src_e        src_next;
  logic              prev_run;

  mdf_class_check u_class (
    .dest(req_dest), .bcast_accept(bcast_accept), .mcast_promisc(mcast_promisc),
    .ucast_promisc(ucast_promisc), .is_bcast(is_bcast), .is_mcast(is_mcast),
    .class_hit(class_hit)
  );

  mdf_exact_table #(.N_ENTRIES(N_ENTRIES)) u_exact (
    .clk(clk), .rst_n(rst_n), .station_addr(station_addr),
    .wr_en(ent_wr_en), .wr_idx(ent_wr_idx), .wr_hi(ent_wr_hi), .wr_data(ent_wr_data),
    .dest(req_dest), .found(exact_hit), .found_idx(exact_idx)
  );

  assign slot = hash_slot(req_dest, hash_offset);

  mdf_hash_table #(.SLOT_W(SLOT_W)) u_hash (
    .clk(clk), .rst_n(rst_n), .wr_en(hash_wr_en), .wr_idx(hash_wr_idx),
    .wr_data(hash_wr_data), .slot(slot), .hit(hash_hit)
  );

  always_comb begin
    if (class_hit)      src_next = SRC_CLASS;
    else if (exact_hit) src_next = SRC_EXACT;
    else if (hash_hit)  src_next = SRC_HASH;
    else                src_next = SRC_REJECT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_accept <= 1'b0;
      rsp_src    <= SRC_REJECT;
      rsp_index  <= '0;
      prev_run   <= 1'b0;
    end else begin
      prev_run  <= 1'b1;
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_accept <= (src_next != SRC_REJECT);
        rsp_src    <= src_next;
        rsp_index  <= (src_next == SRC_EXACT) ? exact_idx : '0;
      end
    end
  end

  // R10: one-cycle response latency.
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prev_run |-> (rsp_valid == $past(req_valid)));
  // R7: accept flag agrees with the source code.
  assert_accept_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept == (rsp_src != SRC_REJECT));
  // R7: index is zero outside exact matches.
  assert_index_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_src != SRC_EXACT) |-> (rsp_index == '0));
  // R1: enabled broadcast is a class accept.
  assert_bcast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prev_run && $past(req_valid && is_bcast && bcast_accept) |-> rsp_src == SRC_CLASS);
  // R2: enabled multicast is a class accept.
  assert_mcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prev_run && $past(req_valid && is_mcast && mcast_promisc) |-> rsp_src == SRC_CLASS);
  // R8: an exact hit with no class accept reports code 2.
  assert_exact_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prev_run && $past(req_valid && exact_hit && !class_hit) |-> rsp_src == SRC_EXACT);
  // R11: disabled broadcast never becomes a class accept.
  assert_bcast_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prev_run && $past(req_valid && is_bcast && !bcast_accept) |-> rsp_src != SRC_CLASS);
endmodule

// File: tb/tb_mac_dest_filter.sv
`timescale 1ns/1ps
module tb_mac_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] station_addr = 48'h5E_4D_3C_2B_1A_02;
  logic        bcast_accept = 0, mcast_promisc = 0, ucast_promisc = 0;
  logic [1:0]  hash_offset = 0;
  logic        ent_wr_en = 0, ent_wr_hi = 0;
  logic [3:0]  ent_wr_idx = 0;
  logic [31:0] ent_wr_data = 0;
  logic        hash_wr_en = 0;
  logic [6:0]  hash_wr_idx = 0;
  logic [31:0] hash_wr_data = 0;
  logic        req_valid = 0;
  logic [47:0] req_dest = 0;
  logic        rsp_valid, rsp_accept;
  logic [1:0]  rsp_src;
  logic [3:0]  rsp_index;

  always #2.5 clk = ~clk;

  mac_dest_filter dut (.*);

  // Bench model of the tables.
  logic [31:0] m_lo [16];
  logic [31:0] m_hi [16];
  logic [31:0] m_hash [128];

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  function automatic logic [11:0] m_slot(logic [47:0] d, logic [1:0] off);
    int sh;
    logic [15:0] v;
    sh = (off == 2'd3) ? 0 : 4 - int'(off);
    v = {d[47:40], d[39:32]};
    return 12'((v >> sh) & 16'h0FFF);
  endfunction

  // Returns {src[1:0], idx[3:0]}.
  function automatic logic [5:0] m_expect(logic [47:0] d);
    logic [11:0] s;
    if (d == {48{1'b1}}) begin
      if (bcast_accept) return {2'd1, 4'd0};
    end else if (d[0]) begin
      if (mcast_promisc) return {2'd1, 4'd0};
    end else if (ucast_promisc) return {2'd1, 4'd0};
    for (int i = 0; i < 16; i++)
      if (m_hi[i][31] && {m_hi[i][15:0], m_lo[i]} == d) return {2'd2, 4'(i)};
    s = m_slot(d, hash_offset);
    if (m_hash[s / 32][s % 32]) return {2'd3, 4'd0};
    return 6'd0;
  endfunction

  task automatic check_rsp(string req, logic [5:0] exp);
    logic [5:0] act;
    n_checks++;
    act = {rsp_src, rsp_index};
    if (!rsp_valid || act != exp || rsp_accept != (exp[5:4] != 0)) begin
      n_fail++;
      $display("FAIL %s: actual valid=%0b acc=%0b src=%0d idx=%0d expected src=%0d idx=%0d",
               req, rsp_valid, rsp_accept, rsp_src, rsp_index, exp[5:4], exp[3:0]);
    end
  endtask

  task automatic lookup(string req, logic [47:0] d);
    logic [5:0] exp;
    @(negedge clk);
    req_valid = 1; req_dest = d;
    exp = m_expect(d);
    @(negedge clk);
    req_valid = 0;
    check_rsp(req, exp);
  endtask

  task automatic lookup_exp(string req, logic [47:0] d, logic [5:0] exp);
    @(negedge clk);
    req_valid = 1; req_dest = d;
    @(negedge clk);
    req_valid = 0;
    check_rsp(req, exp);
  endtask

  task automatic wr_ent(int idx, bit hi, logic [31:0] data);
    @(negedge clk);
    ent_wr_en = 1; ent_wr_idx = 4'(idx); ent_wr_hi = hi; ent_wr_data = data;
    @(negedge clk);
    ent_wr_en = 0;
    if (hi) m_hi[idx] = data; else m_lo[idx] = data;
  endtask

  task automatic set_ent(int idx, logic [47:0] a, bit v);
    wr_ent(idx, 0, a[31:0]);
    wr_ent(idx, 1, {v, 15'd0, a[47:32]});
  endtask

  task automatic wr_hash(int idx, logic [31:0] data);
    @(negedge clk);
    hash_wr_en = 1; hash_wr_idx = 7'(idx); hash_wr_data = data;
    @(negedge clk);
    hash_wr_en = 0;
    m_hash[idx] = data;
  endtask

  task automatic set_hash_bit(logic [11:0] s);
    wr_hash(int'(s[11:5]), m_hash[s[11:5]] | (32'd1 << s[4:0]));
  endtask

  initial begin
    logic [47:0] a;
    logic [11:0] s;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    for (int i = 0; i < 128; i++) m_hash[i] = 0;
    m_lo[0] = station_addr[31:0];
    m_hi[0] = {1'b1, 15'd0, station_addr[47:32]};

    repeat (4) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0 || rsp_accept !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: reset outputs actual valid=%0b acc=%0b expected 0 0", rsp_valid, rsp_accept);
    end
    rst_n = 1;

    // R9: station address in entry 0, others empty, hash clear.
    lookup_exp("R9 station entry", station_addr, {2'd2, 4'd0});
    lookup_exp("R9 empty entries / clear hash", 48'h0, 6'd0);
    lookup_exp("R7 unknown rejected", 48'h12_34_56_78_9A_BC, 6'd0);

    // R10: request valid drops after one cycle.
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fail++; $display("FAIL R10: idle rsp_valid actual=%0b expected=0", rsp_valid);
    end

    // R1 / R11: broadcast.
    bcast_accept = 1;
    lookup_exp("R1 broadcast accepted", {48{1'b1}}, {2'd1, 4'd0});
    bcast_accept = 0; mcast_promisc = 1; ucast_promisc = 1;
    lookup_exp("R11 broadcast not promisc", {48{1'b1}}, 6'd0);
    // R2: multicast and unicast promiscuous.
    ucast_promisc = 0;
    lookup_exp("R2 multicast promisc", 48'hAA_BB_CC_DD_EE_01, {2'd1, 4'd0});
    lookup_exp("R2 unicast not via mcast bit", 48'hAA_BB_CC_DD_EE_02, 6'd0);
    mcast_promisc = 0; ucast_promisc = 1;
    lookup_exp("R2 unicast promisc", 48'hAA_BB_CC_DD_EE_02, {2'd1, 4'd0});
    lookup_exp("R2 multicast not via ucast bit", 48'hAA_BB_CC_DD_EE_01, 6'd0);
    ucast_promisc = 0;

    // R3 / R4 / R5: exact table.
    a = 48'h66_55_44_33_22_10;
    set_ent(9, a, 1'b1);
    lookup_exp("R3 exact byte layout", a, {2'd2, 4'd9});
    lookup_exp("R3 byte-swapped miss", 48'h10_22_33_44_55_66, 6'd0);
    set_ent(4, a, 1'b0);
    lookup_exp("R4 invalid entry skipped", a, {2'd2, 4'd9});
    set_ent(6, a, 1'b1);
    lookup_exp("R5 lowest index", a, {2'd2, 4'd6});
    set_ent(6, a, 1'b0);
    set_ent(9, a, 1'b0);
    lookup_exp("R4 all copies invalid", a, 6'd0);

    // R6: hash slice per offset.
    for (int off = 0; off < 4; off++) begin
      hash_offset = 2'(off);
      a = {16'hB7_C5, 24'h0, 8'h36, 8'h00} | 48'h0000_1000_0000;
      s = m_slot(a, hash_offset);
      set_hash_bit(s);
      lookup_exp($sformatf("R6 hash offset %0d", off), a, {2'd3, 4'd0});
      wr_hash(int'(s[11:5]), 32'd0);
      lookup_exp($sformatf("R6 hash bit cleared offset %0d", off), a, 6'd0);
    end

    // R8: priority class > exact > hash.
    hash_offset = 0;
    a = 48'h0F_0E_0D_0C_0B_0A;
    set_hash_bit(m_slot(a, 0));
    lookup_exp("R8 hash only", a, {2'd3, 4'd0});
    set_ent(12, a, 1'b1);
    lookup_exp("R8 exact over hash", a, {2'd2, 4'd12});
    ucast_promisc = 1;
    lookup_exp("R8 class over exact", a, {2'd1, 4'd0});
    ucast_promisc = 0;

    // R10: write in the same cycle as lookup is not seen.
    a = 48'h99_88_77_66_55_44;
    wr_ent(3, 0, a[31:0]);
    @(negedge clk);
    req_valid = 1; req_dest = a;
    ent_wr_en = 1; ent_wr_idx = 4'd3; ent_wr_hi = 1; ent_wr_data = {1'b1, 15'd0, a[47:32]};
    @(negedge clk);
    req_valid = 0; ent_wr_en = 0;
    m_hi[3] = {1'b1, 15'd0, a[47:32]};
    check_rsp("R10 same-cycle write hidden", m_slot(a,0) == m_slot(48'h0F_0E_0D_0C_0B_0A,0) ? {2'd3,4'd0} : 6'd0);
    lookup_exp("R10 write visible next", a, {2'd2, 4'd3});

    // Random mix (R1-style coverage across all rules, tagged R8).
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) set_ent($urandom_range(0, 15), {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE, 1'($urandom_range(0, 3) != 0));
      else if (r == 1) wr_hash($urandom_range(0, 127), $urandom & $urandom);
      bcast_accept  = ($urandom_range(0, 3) == 0);
      mcast_promisc = ($urandom_range(0, 5) == 0);
      ucast_promisc = ($urandom_range(0, 5) == 0);
      hash_offset   = 2'($urandom_range(0, 3));
      r = $urandom_range(0, 9);
      if (r < 3) begin
        int k;
        k = $urandom_range(0, 15);
        a = {m_hi[k][15:0], m_lo[k]};
      end else if (r == 3) a = {48{1'b1}};
      else a = {16'($urandom), $urandom};
      lookup("R8 random mix", a);
    end

    finish_run();
  end
endmodule